// File: doc/BRIEF.md
# Three-Level Trigger Decision Sequencer

This block takes candidate interactions, one per clock at most, each with a two-bit class code. For every candidate it issues a first-level decision, and then a second-level and a third-level decision for candidates that survive. Each decision comes at a fixed number of cycles after the interaction. Every decision is a one-cycle strobe that carries an accept bit, the event's tag and the event's class. Many events are in flight at the same time. The strobes of different events interleave freely, and within one level they leave in arrival order.

Candidates are protected against pile-up. A candidate loses if another interaction of the same class lands within a class-dependent window, whether before it or after it. A window before the candidate is caught at the first level. A window after it is caught at the next later check. At a later check, a conflicting event can be re-classified through a class-change request instead of being rejected.

Each in-flight event holds one slot of a small pool. Every slot is run by its own state machine:
- `SL_IDLE` moves to `SL_L0_HOLD` when the slot is allocated.
- `SL_L0_HOLD` leaves when its age reaches the first output time. It goes to `SL_IDLE` on a reject and to `SL_L1_WAIT` otherwise.
- `SL_L1_WAIT` moves to `SL_L1_HOLD` at the second-level check time, where it records its verdict.
- `SL_L1_HOLD` leaves at the second output time. It goes to `SL_IDLE` on a reject and to `SL_L2_WAIT` otherwise.
- `SL_L2_WAIT` moves to `SL_L2_HOLD` at the third-level check time.
- `SL_L2_HOLD` returns to `SL_IDLE` at the third output time.

Top module: `trig_sequencer`

## Requirements
- R1: After reset, no decision strobe is high and the overflow count is zero.
- R2: An interaction sampled in cycle A gets a first-level strobe in cycle A+L0_OUT. The strobe carries the event's class. It is an accept when neither busy nor protection applies.
- R3: An interaction sampled while `det_busy` is high gets a first-level reject.
- R4: An interaction is rejected at the first level if an earlier interaction of the same class was sampled at most W cycles before it. W is W_DIMU for class 0, W_DIEL for class 1, and W_OTHER for classes 2 and 3.
- R5: A surviving event is marked if a same-class interaction arrives at most W cycles after it. It is then rejected at its next check: age L1_CHK for the second level, age L2_CHK for the third. An arrival in the check cycle itself counts.
- R6: A marked event at a check while `chg_vld` is high is accepted instead. From that level on it carries class `chg_cls`, and its mark is cleared.
- R7: The tag is the index of the lowest free slot at arrival. The same tag appears on all of that event's strobes.
- R8: An event rejected at one level produces no strobe at any later level.
- R9: Within a level, strobes leave in arrival order.
- R10: An interaction that finds all DEPTH slots in use produces no strobe, and `ovf_cnt` goes up by one.
- R11: Second-level strobes come at A+L1_OUT and third-level strobes at A+L2_OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_vld | input | 1 | Interaction strobe |
| int_cls | input | 2 | Class of the interaction (0, 1, other) |
| det_busy | input | 1 | Detector busy flag, sampled with the interaction |
| chg_vld | input | 1 | Class-change request, used at later checks |
| chg_cls | input | 2 | Replacement class |
| l0_vld | output | 1 | First-level decision strobe |
| l0_acc | output | 1 | First-level accept |
| l0_tag | output | TAG_W | First-level event tag |
| l0_cls | output | 2 | First-level class |
| l1_vld | output | 1 | Second-level decision strobe |
| l1_acc | output | 1 | Second-level accept |
| l1_tag | output | TAG_W | Second-level event tag |
| l1_cls | output | 2 | Second-level class |
| l2_vld | output | 1 | Third-level decision strobe |
| l2_acc | output | 1 | Third-level accept |
| l2_tag | output | TAG_W | Third-level event tag |
| l2_cls | output | 2 | Third-level class |
| ovf_cnt | output | OVF_W | Count of interactions dropped on a full pool |

## Verification
The bench builds the block with short cycle counts and keeps the default pool of 16:
- L0_OUT=2, L1_CHK=5, L1_OUT=7, L2_CHK=40, L2_OUT=44.
- Windows of 2, 4 and 6 cycles.

With these values, a sweep over every class and every spacing from 1 to 8 cycles between two interactions reaches all three outcomes of protection. These are a past hit at the first level, a future hit at the second-level check (including the same-cycle case), and a late hit that only the third-level check sees. The long gap between the second and third checks keeps all 16 slots busy under a burst, so the overflow path and the strobe order can be seen. Re-classification is driven at both later checks.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    localparam int CLS_W = 2;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_L0_HOLD,
        SL_L1_WAIT,
        SL_L1_HOLD,
        SL_L2_WAIT,
        SL_L2_HOLD
    } slot_st_e;

    // protection window of a class: code 0 and code 1 have their own, the rest share one
    function automatic int unsigned win_pick(logic [CLS_W-1:0] c,
                                             int unsigned w_a,
                                             int unsigned w_b,
                                             int unsigned w_x);
        if (c == 2'd0)      return w_a;
        else if (c == 2'd1) return w_b;
        else                return w_x;
    endfunction

endpackage

// File: rtl/trig_guard.sv
// Past-protection history: cycles since the last interaction of each class.
module trig_guard
    import trig_seq_pkg::*;
#(
    parameter int unsigned W_DIMU  = 2,
    parameter int unsigned W_DIEL  = 4,
    parameter int unsigned W_OTHER = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_vld,
    input  logic [CLS_W-1:0] int_cls,
    output logic             past_hit
);
    localparam int unsigned WMAX  = (W_DIMU > W_DIEL) ?
                                    ((W_DIMU > W_OTHER) ? W_DIMU : W_OTHER) :
                                    ((W_DIEL > W_OTHER) ? W_DIEL : W_OTHER);
    localparam int          CNT_W = $clog2(WMAX + 2);
    localparam int          NCLS  = 1 << CLS_W;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WMAX + 1);

    logic [CNT_W-1:0] gap_q [NCLS];

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap_q[c] <= CNT_MAX;
            end else if (int_vld && int_cls == CLS_W'(c)) begin
                gap_q[c] <= CNT_W'(1);
            end else if (gap_q[c] != CNT_MAX) begin
                gap_q[c] <= gap_q[c] + CNT_W'(1);
            end
        end
    end

    always_comb begin
        past_hit = int_vld &&
                   (32'(gap_q[int_cls]) <= win_pick(int_cls, W_DIMU, W_DIEL, W_OTHER));
    end

endmodule

// File: rtl/trig_alloc.sv
// Lowest-free slot pick and overflow count.
module trig_alloc #(
    parameter int DEPTH = 16,
    parameter int OVF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_vld,
    input  logic [DEPTH-1:0] occ,
    output logic [DEPTH-1:0] alloc_oh,
    output logic [OVF_W-1:0] ovf_cnt
);
    logic full;
    logic [DEPTH-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occ[i]) pick = DEPTH'(1) << i;
        end
        full     = &occ;
        alloc_oh = (int_vld && !full) ? pick : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               ovf_cnt <= '0;
        else if (int_vld && full) ovf_cnt <= ovf_cnt + OVF_W'(1);
    end

endmodule

// File: rtl/trig_slot.sv
// One in-flight event: age counter, class, verdict and conflict mark.
module trig_slot
    import trig_seq_pkg::*;
#(
    parameter int unsigned L0_OUT  = 2,
    parameter int unsigned L1_CHK  = 5,
    parameter int unsigned L1_OUT  = 7,
    parameter int unsigned L2_CHK  = 40,
    parameter int unsigned L2_OUT  = 44,
    parameter int unsigned W_DIMU  = 2,
    parameter int unsigned W_DIEL  = 4,
    parameter int unsigned W_OTHER = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [CLS_W-1:0] new_cls,
    input  logic             new_rej,
    input  logic             new_past,
    input  logic             arr_vld,
    input  logic [CLS_W-1:0] arr_cls,
    input  logic             chg_vld,
    input  logic [CLS_W-1:0] chg_cls,
    output logic             occ,
    output logic             fire0,
    output logic             fire1,
    output logic             fire2,
    output logic             acc,
    output logic [CLS_W-1:0] cls
);
    localparam int AGE_W = $clog2(L2_OUT + 2);

    slot_st_e         st_q, st_d;
    logic [AGE_W-1:0] age_q, age_d;
    logic [CLS_W-1:0] cls_q, cls_d;
    logic             rej_q, rej_d;
    logic             conf_q, conf_d;
    logic             fut_hit, conf_now;

    always_comb begin
        fut_hit  = arr_vld && (st_q != SL_IDLE) && (arr_cls == cls_q) &&
                   (32'(age_q) <= win_pick(cls_q, W_DIMU, W_DIEL, W_OTHER));
        conf_now = conf_q || fut_hit;
    end

    // next state and data
    always_comb begin
        st_d   = st_q;
        cls_d  = cls_q;
        rej_d  = rej_q;
        conf_d = conf_now;
        age_d  = (st_q == SL_IDLE) ? '0 : age_q + AGE_W'(1);
        unique case (st_q)
            SL_IDLE: begin
                if (alloc) begin
                    st_d   = SL_L0_HOLD;
                    cls_d  = new_cls;
                    rej_d  = new_rej;
                    conf_d = new_past;
                    age_d  = AGE_W'(1);
                end
            end
            SL_L0_HOLD: begin
                if (age_q == AGE_W'(L0_OUT)) st_d = rej_q ? SL_IDLE : SL_L1_WAIT;
            end
            SL_L1_WAIT, SL_L2_WAIT: begin
                if ((st_q == SL_L1_WAIT && age_q == AGE_W'(L1_CHK)) ||
                    (st_q == SL_L2_WAIT && age_q == AGE_W'(L2_CHK))) begin
                    st_d  = (st_q == SL_L1_WAIT) ? SL_L1_HOLD : SL_L2_HOLD;
                    rej_d = 1'b0;
                    if (conf_now) begin
                        if (chg_vld) begin
                            cls_d  = chg_cls;
                            conf_d = 1'b0;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end
                end
            end
            SL_L1_HOLD: begin
                if (age_q == AGE_W'(L1_OUT)) st_d = rej_q ? SL_IDLE : SL_L2_WAIT;
            end
            SL_L2_HOLD: begin
                if (age_q == AGE_W'(L2_OUT)) st_d = SL_IDLE;
            end
            default: st_d = SL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SL_IDLE;
            age_q  <= '0;
            cls_q  <= '0;
            rej_q  <= 1'b0;
            conf_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            age_q  <= age_d;
            cls_q  <= cls_d;
            rej_q  <= rej_d;
            conf_q <= conf_d;
        end
    end

    // outputs
    always_comb begin
        occ   = (st_q != SL_IDLE);
        fire0 = (st_q == SL_L0_HOLD) && (age_q == AGE_W'(L0_OUT));
        fire1 = (st_q == SL_L1_HOLD) && (age_q == AGE_W'(L1_OUT));
        fire2 = (st_q == SL_L2_HOLD) && (age_q == AGE_W'(L2_OUT));
        acc   = !rej_q;
        cls   = cls_q;
    end

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
    import trig_seq_pkg::*;
#(
    parameter int unsigned CLK_PS  = 25000,
    parameter int unsigned L0_OUT  = 1200000 / CLK_PS,
    parameter int unsigned L1_CHK  = 4300000 / CLK_PS,
    parameter int unsigned L1_OUT  = 5500000 / CLK_PS,
    parameter int unsigned L2_CHK  = 88000000 / CLK_PS,
    parameter int unsigned L2_OUT  = 89200000 / CLK_PS,
    parameter int unsigned W_DIMU  = 3000000 / CLK_PS,
    parameter int unsigned W_DIEL  = 7000000 / CLK_PS,
    parameter int unsigned W_OTHER = 88000000 / CLK_PS,
    parameter int          DEPTH   = 16,
    parameter int          OVF_W   = 16,
    localparam int         TAG_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_vld,
    input  logic [1:0]       int_cls,
    input  logic             det_busy,
    input  logic             chg_vld,
    input  logic [1:0]       chg_cls,
    output logic             l0_vld,
    output logic             l0_acc,
    output logic [TAG_W-1:0] l0_tag,
    output logic [1:0]       l0_cls,
    output logic             l1_vld,
    output logic             l1_acc,
    output logic [TAG_W-1:0] l1_tag,
    output logic [1:0]       l1_cls,
    output logic             l2_vld,
    output logic             l2_acc,
    output logic [TAG_W-1:0] l2_tag,
    output logic [1:0]       l2_cls,
    output logic [OVF_W-1:0] ovf_cnt
);
    logic             past_hit;
    logic [DEPTH-1:0] occ, alloc_oh, fire0, fire1, fire2, s_acc;
    logic [CLS_W-1:0] s_cls [DEPTH];

    trig_guard #(
        .W_DIMU (W_DIMU),
        .W_DIEL (W_DIEL),
        .W_OTHER(W_OTHER)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_vld (int_vld),
        .int_cls (int_cls),
        .past_hit(past_hit)
    );

    trig_alloc #(
        .DEPTH(DEPTH),
        .OVF_W(OVF_W)
    ) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_vld (int_vld),
        .occ     (occ),
        .alloc_oh(alloc_oh),
        .ovf_cnt (ovf_cnt)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        trig_slot #(
            .L0_OUT (L0_OUT),
            .L1_CHK (L1_CHK),
            .L1_OUT (L1_OUT),
            .L2_CHK (L2_CHK),
            .L2_OUT (L2_OUT),
            .W_DIMU (W_DIMU),
            .W_DIEL (W_DIEL),
            .W_OTHER(W_OTHER)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc   (alloc_oh[i]),
            .new_cls (int_cls),
            .new_rej (det_busy || past_hit),
            .new_past(past_hit),
            .arr_vld (int_vld),
            .arr_cls (int_cls),
            .chg_vld (chg_vld),
            .chg_cls (chg_cls),
            .occ     (occ[i]),
            .fire0   (fire0[i]),
            .fire1   (fire1[i]),
            .fire2   (fire2[i]),
            .acc     (s_acc[i]),
            .cls     (s_cls[i])
        );
    end

    // decision outputs: at most one slot fires per level in a cycle
    always_comb begin
        {l0_vld, l0_acc, l0_tag, l0_cls} = '0;
        {l1_vld, l1_acc, l1_tag, l1_cls} = '0;
        {l2_vld, l2_acc, l2_tag, l2_cls} = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (fire0[i]) begin
                l0_vld = 1'b1; l0_acc = s_acc[i]; l0_tag = TAG_W'(i); l0_cls = s_cls[i];
            end
            if (fire1[i]) begin
                l1_vld = 1'b1; l1_acc = s_acc[i]; l1_tag = TAG_W'(i); l1_cls = s_cls[i];
            end
            if (fire2[i]) begin
                l2_vld = 1'b1; l2_acc = s_acc[i]; l2_tag = TAG_W'(i); l2_cls = s_cls[i];
            end
        end
    end

endmodule

// File: rtl/trig_sequencer_chk.sv
module trig_sequencer_chk #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 4,
    parameter int OVF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_vld,
    input logic [1:0]       int_cls,
    input logic             det_busy,
    input logic             chg_vld,
    input logic [1:0]       chg_cls,
    input logic             l0_vld,
    input logic             l0_acc,
    input logic [TAG_W-1:0] l0_tag,
    input logic [1:0]       l0_cls,
    input logic             l1_vld,
    input logic             l1_acc,
    input logic [TAG_W-1:0] l1_tag,
    input logic [1:0]       l1_cls,
    input logic             l2_vld,
    input logic             l2_acc,
    input logic [TAG_W-1:0] l2_tag,
    input logic [1:0]       l2_cls,
    input logic [OVF_W-1:0] ovf_cnt
);
    logic [DEPTH-1:0] may_l1, may_l2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            may_l1 <= '0;
            may_l2 <= '0;
        end else begin
            if (l0_vld && l0_acc) may_l1[l0_tag] <= 1'b1;
            if (l1_vld) begin
                may_l1[l1_tag] <= 1'b0;
                if (l1_acc) may_l2[l1_tag] <= 1'b1;
            end
            if (l2_vld) may_l2[l2_tag] <= 1'b0;
        end
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!l0_vld && !l1_vld && !l2_vld && ovf_cnt == '0));

    p_l1_needs_l0_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        l1_vld |-> may_l1[l1_tag]);

    p_l2_needs_l1_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        l2_vld |-> may_l2[l2_tag]);

    p_no_overflow_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ovf_cnt) |-> (ovf_cnt == OVF_W'($past(ovf_cnt) + 1'b1)) && $past(int_vld));

endmodule

bind trig_sequencer trig_sequencer_chk #(
    .DEPTH(DEPTH),
    .TAG_W(TAG_W),
    .OVF_W(OVF_W)
) u_chk (.*);

// File: tb/test_trig_sequencer.sv
module test_trig_sequencer;
    localparam int CLK_NS = 10;
    localparam int P_L0 = 2, P_L1C = 5, P_L1 = 7, P_L2C = 40, P_L2 = 44;
    localparam int W0 = 2, W1 = 4, WX = 6;
    localparam int TW = 4;
    localparam int OW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic int_vld = 1'b0, det_busy = 1'b0, chg_vld = 1'b0;
    logic [1:0] int_cls = '0, chg_cls = '0;
    logic l0_vld, l0_acc, l1_vld, l1_acc, l2_vld, l2_acc;
    logic [TW-1:0] l0_tag, l1_tag, l2_tag;
    logic [1:0] l0_cls, l1_cls, l2_cls;
    logic [OW-1:0] ovf_cnt;

    int nchk = 0, nerr = 0, cyc = 0;
    int obs_n [3];
    int obs_cyc [3][20], obs_tag [3][20], obs_acc [3][20], obs_cls [3][20];
    int exp_n [3];
    int exp_cyc [3][20], exp_tag [3][20], exp_acc [3][20], exp_cls [3][20];
    bit done = 0;

    always #(CLK_NS / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trig_sequencer #(
        .L0_OUT(P_L0), .L1_CHK(P_L1C), .L1_OUT(P_L1), .L2_CHK(P_L2C), .L2_OUT(P_L2),
        .W_DIMU(W0), .W_DIEL(W1), .W_OTHER(WX), .DEPTH(16), .OVF_W(OW)
    ) i_trig_sequencer (
        .clk(clk), .rst_n(rst_n), .int_vld(int_vld), .int_cls(int_cls),
        .det_busy(det_busy), .chg_vld(chg_vld), .chg_cls(chg_cls),
        .l0_vld(l0_vld), .l0_acc(l0_acc), .l0_tag(l0_tag), .l0_cls(l0_cls),
        .l1_vld(l1_vld), .l1_acc(l1_acc), .l1_tag(l1_tag), .l1_cls(l1_cls),
        .l2_vld(l2_vld), .l2_acc(l2_acc), .l2_tag(l2_tag), .l2_cls(l2_cls),
        .ovf_cnt(ovf_cnt)
    );

    task automatic note(int lv, int cy, int tg, int ac, int cl);
        int k = obs_n[lv];
        if (k < 20) begin
            obs_cyc[lv][k] = cy; obs_tag[lv][k] = tg;
            obs_acc[lv][k] = ac; obs_cls[lv][k] = cl;
        end
        obs_n[lv] = k + 1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (l0_vld) note(0, cyc, int'(l0_tag), int'(l0_acc), int'(l0_cls));
            if (l1_vld) note(1, cyc, int'(l1_tag), int'(l1_acc), int'(l1_cls));
            if (l2_vld) note(2, cyc, int'(l2_tag), int'(l2_acc), int'(l2_cls));
        end
    end

    task automatic chk(string req, string what, int act, int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clr();
        for (int lv = 0; lv < 3; lv++) begin
            obs_n[lv] = 0;
            exp_n[lv] = 0;
        end
    endtask

    task automatic want(int lv, int cy, int tg, int ac, int cl);
        int k = exp_n[lv];
        exp_cyc[lv][k] = cy; exp_tag[lv][k] = tg;
        exp_acc[lv][k] = ac; exp_cls[lv][k] = cl;
        exp_n[lv] = k + 1;
    endtask

    // compare observed strobe lists with expected ones, level by level
    task automatic compare(string req);
        for (int lv = 0; lv < 3; lv++) begin
            chk(req, $sformatf("level %0d strobe count", lv), obs_n[lv], exp_n[lv]);
            for (int k = 0; k < exp_n[lv] && k < obs_n[lv]; k++) begin
                chk(req, $sformatf("level %0d #%0d cycle", lv, k), obs_cyc[lv][k], exp_cyc[lv][k]);
                chk(req, $sformatf("level %0d #%0d tag", lv, k), obs_tag[lv][k], exp_tag[lv][k]);
                chk(req, $sformatf("level %0d #%0d accept", lv, k), obs_acc[lv][k], exp_acc[lv][k]);
                chk(req, $sformatf("level %0d #%0d class", lv, k), obs_cls[lv][k], exp_cls[lv][k]);
            end
        end
    endtask

    function automatic int win(int c);
        return (c == 0) ? W0 : (c == 1) ? W1 : WX;
    endfunction

    // two same-class interactions d cycles apart (R2 R4 R5 R6 R7 R8 R11)
    task automatic pair(int c, int d, bit use_chg, int nc);
        int a;
        bit hit, early;
        clr();
        chg_vld = use_chg;
        chg_cls = 2'(nc);
        a = cyc;
        int_vld = 1'b1; int_cls = 2'(c);
        @(negedge clk);
        if (d > 1) begin
            int_vld = 1'b0;
            repeat (d - 1) @(negedge clk);
        end
        int_vld = 1'b1;
        @(negedge clk);
        int_vld = 1'b0;
        repeat (P_L2 + 20) @(negedge clk);
        chg_vld = 1'b0;

        hit   = (d <= win(c));
        early = hit && (d <= P_L1C);
        want(0, a + P_L0, 0, 1, c);
        want(0, a + d + P_L0, 1, hit ? 0 : 1, c);
        if (early) begin
            want(1, a + P_L1, 0, use_chg ? 1 : 0, use_chg ? nc : c);
            if (use_chg) want(2, a + P_L2, 0, 1, nc);
        end else if (hit) begin
            want(1, a + P_L1, 0, 1, c);
            want(2, a + P_L2, 0, use_chg ? 1 : 0, use_chg ? nc : c);
        end else begin
            want(1, a + P_L1, 0, 1, c);
            want(1, a + d + P_L1, 1, 1, c);
            want(2, a + P_L2, 0, 1, c);
            want(2, a + d + P_L2, 1, 1, c);
        end
        compare(use_chg ? "R6" : (hit ? (early ? "R4 R5 R8" : "R4 R5 R11") : "R2 R7 R9 R11"));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            finish_run();
        end
    end

    initial begin
        int a;
        int ovf0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr();
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        chk("R1", "l0_vld", int'(l0_vld), 0);
        chk("R1", "l1_vld", int'(l1_vld), 0);
        chk("R1", "l2_vld", int'(l2_vld), 0);
        chk("R1", "ovf_cnt", int'(ovf_cnt), 0);

        // R3: busy detector rejects at the first level, nothing later (R8)
        clr();
        a = cyc;
        int_vld = 1'b1; int_cls = 2'd2; det_busy = 1'b1;
        @(negedge clk);
        int_vld = 1'b0; det_busy = 1'b0;
        repeat (P_L2 + 20) @(negedge clk);
        want(0, a + P_L0, 0, 0, 2);
        compare("R3 R8");

        // sweep of class and spacing: R4 R5 at every boundary
        for (int c = 0; c < 4; c++) begin
            for (int d = 1; d <= 8; d++) pair(c, d, 1'b0, 0);
        end

        // R6: re-classification at the second-level and at the third-level check
        pair(0, 1, 1'b1, 3);
        pair(2, 6, 1'b1, 1);
        pair(1, 3, 1'b1, 2);

        // R10 R9 R7: burst of 17, spaced 2, classes rotating, pool of 16
        clr();
        ovf0 = int'(ovf_cnt);
        a = cyc;
        for (int i = 0; i <= 16; i++) begin
            int_vld = 1'b1; int_cls = 2'(i % 4);
            @(negedge clk);
            int_vld = 1'b0;
            @(negedge clk);
        end
        repeat (P_L2 + 30) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            want(0, a + 2 * i + P_L0, i, 1, i % 4);
            want(1, a + 2 * i + P_L1, i, 1, i % 4);
        end
        for (int i = 0; i < 16; i++) want(2, a + 2 * i + P_L2, i, 1, i % 4);
        compare("R10 R9 R7");
        chk("R10", "ovf_cnt step", int'(ovf_cnt) - ovf0, 1);

        // R10: pool free again, a lone event goes through with tag 0
        pair(3, 8, 1'b0, 0);
        chk("R10", "ovf_cnt unchanged", int'(ovf_cnt) - ovf0, 1);

        done = 1;
        finish_run();
    end

endmodule